// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32.768 kHz timebase into a programmable periodic event. A single-cycle enable marks each timebase period within the fast system clock. A 14-bit counter advances on each enable. A 4-bit rate code selects a power-of-two period, from 4 to 16384 timebase cycles. A tick fires each time the low bits of the counter that belong to the chosen period all return to zero. Ticks therefore line up with multiples of the period on the free-running count, and not with the moment the rate was programmed.

On every tick the block gives a one-cycle periodic-flag strobe. An interrupt-set strobe goes with it when periodic interrupts are enabled. A one-cycle pulse on the square-wave output goes with it when the square-wave path is enabled. A 3-bit divider-control field can let the counter run, freeze it, or hold it cleared. Clearing the counter gives software a way to start a fresh, known phase.

Top module: `periodic_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all three output strobes are low.
- R2: A rate code of 0 stops the generator, and no strobe is produced.
- R3: Rate codes 1 and 2 give the same periods as codes 8 and 9, which are 128 and 256 timebase cycles.
- R4: For rate codes 3 to 15, the tick period is 2^(code-1) timebase enables, so code 3 gives 4 and code 15 gives 16384. Ticks occur only on a clock where the timebase enable was high.
- R5: With both the interrupt enable and the square-wave enable low, no strobe is produced.
- R6: A tick fires on the timebase enable that brings the free-running counter to a multiple of the period. The strobes are registered and appear one clock after that edge. When enables are sparse, the period is counted in enables, not in clocks.
- R7: The interrupt-set strobe is high only together with the periodic-flag strobe, and only when the interrupt enable was high.
- R8: When the square-wave enable is set, each tick produces exactly one single-cycle pulse on the square-wave output. The output is not a level waveform.
- R9: A divider-control value of 6 or 7 holds the counter at zero. After release to a running value, the first tick comes after one full period of enables.
- R10: Divider-control values 3, 4 and 5 freeze the counter, and no ticks occur. Values 0, 1 and 2 let it run. After a freeze the count resumes from where it stopped.
- R11: A rate code changed in the middle of a period takes effect at the next boundary of the new period on the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | One-cycle enable per 32.768 kHz timebase period |
| rate_sel | input | 4 | Rate code (0 = off) |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave path enable |
| div_ctl | input | 3 | Divider control: 0-2 run, 3-5 freeze, 6-7 hold cleared |
| pf_set | output | 1 | Periodic-flag set strobe |
| irq_set | output | 1 | Interrupt-set strobe |
| sqw_pulse | output | 1 | Square-wave pulse |

## Verification
The phase of the counter cannot be seen at the ports. The hard cases are those that depend on it: the alignment of the first tick, a rate change in the middle of a period, and resuming after a freeze. The stimulus first pulses the divider control into its clear state, which brings the counter to a known zero. It then counts enables up to a chosen point before it changes the rate or freezes the counter. The position of the first tick in the measured window then shows whether the phase was carried correctly. Enables are also sent one clock in three, which separates counting enables from counting clocks.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int unsigned PTG_CNT_W  = 14;
  localparam int unsigned PTG_RATE_W = 4;
  localparam int unsigned PTG_DIV_W  = 3;

  typedef enum logic [1:0] {
    DIV_RUN    = 2'd0,
    DIV_FREEZE = 2'd1,
    DIV_CLEAR  = 2'd2
  } div_mode_e;

  typedef struct packed {
    logic pf;
    logic irq;
    logic sqw;
  } tick_evt_t;
endpackage

// File: rtl/ptg_div_ctrl.sv
module ptg_div_ctrl
  import ptg_pkg::*;
#(
  parameter int unsigned DIV_W = PTG_DIV_W
) (
  input  logic [DIV_W-1:0] div_ctl,
  output div_mode_e        mode
);
  localparam logic [DIV_W-1:0] RUN_MAX   = DIV_W'(2);
  localparam logic [DIV_W-1:0] CLEAR_MIN = DIV_W'(6);

  always_comb begin
    if (div_ctl >= CLEAR_MIN)     mode = DIV_CLEAR;
    else if (div_ctl <= RUN_MAX)  mode = DIV_RUN;
    else                          mode = DIV_FREEZE;
  end
endmodule

// File: rtl/ptg_timebase.sv
module ptg_timebase
  import ptg_pkg::*;
#(
  parameter int unsigned CNT_W = PTG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  div_mode_e        mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             step
);
  logic [CNT_W-1:0] cnt_d;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign step    = tb_en && (mode == DIV_RUN);

  always_comb begin
    cnt_d = cnt_q;
    if (mode == DIV_CLEAR) cnt_d = '0;
    else if (step)         cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ptg_rate_map.sv
module ptg_rate_map
  import ptg_pkg::*;
#(
  parameter int unsigned RATE_W = PTG_RATE_W,
  parameter int unsigned CNT_W  = PTG_CNT_W
) (
  input  logic [RATE_W-1:0] rate_sel,
  output logic              rate_on,
  output logic [CNT_W-1:0]  phase_mask
);
  localparam logic [RATE_W-1:0] ALIAS_LO  = RATE_W'(1);
  localparam logic [RATE_W-1:0] ALIAS_HI  = RATE_W'(2);
  localparam logic [RATE_W-1:0] ALIAS_OFS = RATE_W'(7);

  logic [RATE_W-1:0] eff_code;

  assign rate_on = (rate_sel != '0);

  always_comb begin
    if (rate_sel == ALIAS_LO || rate_sel == ALIAS_HI) eff_code = rate_sel + ALIAS_OFS;
    else                                              eff_code = rate_sel;
  end

  // bit i of the mask participates when the period exceeds 2^i
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign phase_mask[i] = (32'(eff_code) > (i + 1));
  end
endmodule

// File: rtl/ptg_tick_out.sv
module ptg_tick_out
  import ptg_pkg::*;
#(
  parameter int unsigned CNT_W = PTG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             rate_on,
  input  logic [CNT_W-1:0] cnt_inc,
  input  logic [CNT_W-1:0] phase_mask,
  input  logic             pie_en,
  input  logic             sqw_en,
  output tick_evt_t        evt_q
);
  logic      active;
  logic      boundary;
  tick_evt_t evt_d;

  assign active   = rate_on && (pie_en || sqw_en);
  assign boundary = ((cnt_inc & phase_mask) == '0);

  always_comb begin
    evt_d     = '0;
    evt_d.pf  = step && active && boundary;
    evt_d.irq = evt_d.pf && pie_en;
    evt_d.sqw = evt_d.pf && sqw_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
  import ptg_pkg::*;
#(
  parameter int unsigned CNT_W  = PTG_CNT_W,
  parameter int unsigned RATE_W = PTG_RATE_W,
  parameter int unsigned DIV_W  = PTG_DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  input  logic              sqw_en,
  input  logic [DIV_W-1:0]  div_ctl,
  output logic              pf_set,
  output logic              irq_set,
  output logic              sqw_pulse
);
  div_mode_e        mode;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] phase_mask;
  logic             step;
  logic             rate_on;
  tick_evt_t        evt_q;

  ptg_div_ctrl #(.DIV_W(DIV_W)) u_div (
    .div_ctl (div_ctl),
    .mode    (mode)
  );

  ptg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tb_en   (tb_en),
    .mode    (mode),
    .cnt_q   (cnt_q),
    .cnt_inc (cnt_inc),
    .step    (step)
  );

  ptg_rate_map #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_rate (
    .rate_sel   (rate_sel),
    .rate_on    (rate_on),
    .phase_mask (phase_mask)
  );

  ptg_tick_out #(.CNT_W(CNT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .rate_on    (rate_on),
    .cnt_inc    (cnt_inc),
    .phase_mask (phase_mask),
    .pie_en     (pie_en),
    .sqw_en     (sqw_en),
    .evt_q      (evt_q)
  );

  assign pf_set    = evt_q.pf;
  assign irq_set   = evt_q.irq;
  assign sqw_pulse = evt_q.sqw;
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned RATE_W = 4,
  parameter int unsigned DIV_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tb_en,
  input logic [RATE_W-1:0] rate_sel,
  input logic              pie_en,
  input logic              sqw_en,
  input logic [DIV_W-1:0]  div_ctl,
  input logic              pf_set,
  input logic              irq_set,
  input logic              sqw_pulse,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_IRQ_WITH_PF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (pf_set && $past(pie_en))); // R7
  AST_SQW_WITH_PF: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> (pf_set && $past(sqw_en))); // R8
  AST_SQW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |=> !sqw_pulse); // R8
  AST_RATE_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> ($past(rate_sel) != '0)); // R2
  AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> ($past(pie_en) || $past(sqw_en))); // R5
  AST_ON_TIMEBASE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> $past(tb_en)); // R4
  AST_ALIGN_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_set && $past(rate_sel) == RATE_W'(3)) |-> (cnt_q[1:0] == 2'b00)); // R6
  AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl >= DIV_W'(6)) |=> (cnt_q == '0)); // R9
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl >= DIV_W'(3) && div_ctl <= DIV_W'(5)) |=> ($stable(cnt_q) && !pf_set)); // R10
endmodule

bind periodic_tick_gen ptg_checker #(.CNT_W(CNT_W), .RATE_W(RATE_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_en     (tb_en),
  .rate_sel  (rate_sel),
  .pie_en    (pie_en),
  .sqw_en    (sqw_en),
  .div_ctl   (div_ctl),
  .pf_set    (pf_set),
  .irq_set   (irq_set),
  .sqw_pulse (sqw_pulse),
  .cnt_q     (cnt_q)
);

// File: tb/periodic_tick_gen_tb.sv
`timescale 1ns/1ps
module periodic_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_en;
  logic [3:0] rate_sel;
  logic       pie_en, sqw_en;
  logic [2:0] div_ctl;
  logic       pf_set, irq_set, sqw_pulse;

  int tests = 0;
  int fails = 0;
  string req_tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  periodic_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .rate_sel(rate_sel),
    .pie_en(pie_en), .sqw_en(sqw_en), .div_ctl(div_ctl),
    .pf_set(pf_set), .irq_set(irq_set), .sqw_pulse(sqw_pulse)
  );

  // behavioural reference
  int m_cnt = 0;
  bit e_pf = 0, e_irq = 0, e_sqw = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; e_pf = 0; e_irq = 0; e_sqw = 0;
    end else begin
      int code;
      int period;
      bit t;
      code = int'(rate_sel);
      if (code == 1) code = 8;
      if (code == 2) code = 9;
      period = (code == 0) ? 1 : (1 << (code - 1));
      t = 0;
      if (div_ctl >= 6) m_cnt = 0;
      else if (div_ctl <= 2 && tb_en) begin
        m_cnt = (m_cnt + 1) % 16384;
        if (rate_sel != 0 && (pie_en || sqw_en) && (m_cnt % period) == 0) t = 1;
      end
      e_pf = t; e_irq = t && pie_en; e_sqw = t && sqw_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (pf_set !== e_pf || irq_set !== e_irq || sqw_pulse !== e_sqw) begin
        fails++;
        $display("FAIL %s cycle compare: got pf/irq/sqw=%b%b%b expected %b%b%b",
                 req_tag, pf_set, irq_set, sqw_pulse, e_pf, e_irq, e_sqw);
      end
    end
  end

  task automatic check(input string r, input int got, input int exp, input string what);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
    end
  endtask

  int npf, nirq, nsqw, first;

  task automatic window(input int n, input int d);
    npf = 0; nirq = 0; nsqw = 0; first = 0;
    for (int i = 0; i < n; i++) begin
      tb_en = ((i % d) == d - 1);
      @(negedge clk);
      if (pf_set) begin npf++; if (first == 0) first = i + 1; end
      if (irq_set) nirq++;
      if (sqw_pulse) nsqw++;
    end
    tb_en = 1'b0;
  endtask

  task automatic realign();
    div_ctl = 3'd6;
    repeat (2) @(negedge clk);
    div_ctl = 3'd2;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; tb_en = 1'b0; rate_sel = 4'd0; pie_en = 1'b0; sqw_en = 1'b0; div_ctl = 3'd2;
    repeat (3) @(negedge clk);
    check("R1", int'({pf_set, irq_set, sqw_pulse}), 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({pf_set, irq_set, sqw_pulse}), 0, "outputs after reset");

    req_tag = "R4"; rate_sel = 4'd3; pie_en = 1'b1;
    realign(); window(64, 1);
    check("R4", npf, 16, "code 3 ticks in 64");
    check("R9", first, 4, "first tick after clear release");
    rate_sel = 4'd6; realign(); window(128, 1);
    check("R4", npf, 4, "code 6 ticks in 128");

    req_tag = "R3"; rate_sel = 4'd1; realign(); window(1024, 1);
    check("R3", npf, 8, "code 1 ticks in 1024");
    rate_sel = 4'd2; realign(); window(1024, 1);
    check("R3", npf, 4, "code 2 ticks in 1024");
    check("R3", first, 256, "code 2 first tick");

    req_tag = "R7"; rate_sel = 4'd3; pie_en = 1'b0; sqw_en = 1'b1; realign(); window(64, 1);
    check("R7", nirq, 0, "irq with pie off");
    check("R8", nsqw, 16, "square pulses");
    check("R8", npf, 16, "flag with square only");

    req_tag = "R5"; sqw_en = 1'b0; realign(); window(64, 1);
    check("R5", npf, 0, "no enables");

    req_tag = "R2"; pie_en = 1'b1; rate_sel = 4'd0; realign(); window(64, 1);
    check("R2", npf, 0, "rate zero");

    req_tag = "R10"; rate_sel = 4'd3; realign(); window(2, 1);
    div_ctl = 3'd4; window(50, 1);
    check("R10", npf, 0, "frozen ticks");
    div_ctl = 3'd1; window(16, 1);
    check("R10", first, 2, "resume phase");

    req_tag = "R11"; rate_sel = 4'd5; realign(); window(6, 1);
    rate_sel = 4'd4; window(32, 1);
    check("R11", first, 2, "new rate boundary");

    req_tag = "R6"; rate_sel = 4'd3; realign(); window(120, 3);
    check("R6", npf, 10, "sparse enable ticks");
    check("R6", first, 12, "sparse first tick");

    req_tag = "R4"; rate_sel = 4'd15; realign(); window(16384, 1);
    check("R4", npf, 1, "code 15 ticks");
    check("R4", first, 16384, "code 15 first tick");

    summary();
  end
endmodule